// File: doc/BRIEF.md
# Serial Command Port with Fault Echo

This block is the serial control port of a six-channel low-side gate driver controller. A host selects the port by pulling the active-low select line low. It then clocks a command word of one or two bytes into the serial input, most significant bit first. When the select line returns high, the last byte received becomes the channel command. Bits 0 to 5 of that byte switch gates 0 to 5 on, where 1 means on. Bit 6 is the PWM-mode monitor bit and bit 7 is unused. The host sends both of these bits as 0.

While the port is selected, the serial output streams back data for the host to verify. It starts with the command held before the transfer and continues with the bits just received, so one byte of delay sits between input and output. A channel's bit position is inverted when that channel reported a fault. The fault flags are frozen when the select line falls and stay frozen until it rises again. The mode-bit position is inverted while the PWM override input is high. The output is driven only while the port is selected and the override is low. The tristate is modelled as an enable signal.

The serial clock and select are treated as synchronous inputs. They are sampled by a faster system clock and edge-detected. The command register is cleared by reset, so all gates start off. It updates only when exactly 8 or 16 serial clock rising edges were seen during the select-low window.

Top module: `spi_diag_port`

## Requirements
- R1: After reset, gate_en is 0, mode_mon is 0 and so_oe is 0.
- R2: si is sampled on each sck rising edge while cs_n is low, most significant bit first. Of the stored byte, bit k (k = 0..5) drives gate_en[k], bit 6 drives mode_mon and bit 7 is unused.
- R3: so changes only on an sck falling edge, or in the clock where cs_n falls. In that clock it presents the most significant bit of the current command. A rising sck edge leaves so unchanged.
- R4: Bit i of the output stream is the previous command's bits, MSB first, followed by the received bits. At byte position p = 7 - (i mod 8), the bit is inverted when p < 6 and the frozen fault flag p is set. It is inverted when p = 6 and pwm_mode is high at the falling edge that presents it.
- R5: fault is captured in the clock where cs_n falls, including a change arriving in that same clock. Changes while cs_n stays low do not alter the echo.
- R6: so_oe is 1 exactly one clock after a clock in which cs_n is low and pwm_mode is low, and 0 otherwise.
- R7: On the rising edge of cs_n, the command takes the last 8 received bits only if exactly 8 or 16 sck rising edges were counted. Otherwise the previous command is kept.
- R8: In a 16-bit transfer, the first byte shifted in appears, with fault inversion, as the second byte shifted out. The second byte in becomes the command.
- R9: sck edges while cs_n is high are ignored. They do not count toward the transfer length and do not enter the shift chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial bit clock |
| cs_n | input | 1 | Active-low port select |
| si | input | 1 | Serial command input |
| pwm_mode | input | 1 | PWM override mode, active high |
| fault | input | 6 | Per-channel fault flags |
| so | output | 1 | Serial status output |
| so_oe | output | 1 | Output enable for so (0 = high impedance) |
| gate_en | output | 6 | Latched gate enable per channel |
| mode_mon | output | 1 | Latched mode monitor bit |

## Verification
Two events are made to land in the same system clock. The first case is a fault change in the very clock where cs_n falls; the echo of the previous command is expected to carry the new fault pattern. The second case is a one-clock pwm_mode pulse in the same clock as the sck falling edge that presents the mode-bit position. That bit must be inverted and hold after the pulse ends, while so_oe drops for exactly the one following clock. A behavioural stream model in the bench predicts so, so_oe and the command on every clock and judges both cases.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  localparam int unsigned WORD_BITS  = 8;
  localparam int unsigned CHAN_COUNT = 6;

  // Width of a transfer-length counter that must reach two words plus one.
  function automatic int unsigned len_cnt_width(input int unsigned w);
    return $clog2(2 * w + 2);
  endfunction
endpackage

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter int N = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= IDLE;
    else     d_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = sig[i] & ~d_q[i];
    assign fall[i] = ~sig[i] & d_q[i];
  end
endmodule

// File: rtl/spi_fault_snap.sv
module spi_fault_snap #(
  parameter int CH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          track,
  input  logic [CH-1:0] fault,
  output logic [CH-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst)        snap <= '0;
    else if (track) snap <= fault;
  end

  // R5: snapshot frozen while the select stays low
  assert_snap_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$past(rst)) |=> $stable(snap));
endmodule

// File: rtl/spi_shift_chain.sv
module spi_shift_chain #(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic          drive,
  input  logic          si,
  input  logic [W-1:0]  load_val,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  chain,
  output logic [CW-1:0] cnt,
  output logic          so_q
);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CMAX = CW'(2 * W + 1);
  localparam logic [PW-1:0] PLAST = PW'(W - 1);

  logic [W-1:0]  chain_q;
  logic [PW-1:0] bpos;
  logic          so_next;

  assign chain = chain_q;

  always_comb begin
    so_next = chain_q[W-1] ^ mask[(W - 1) - int'(bpos)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      cnt     <= '0;
      bpos    <= '0;
      so_q    <= 1'b0;
    end else if (load) begin
      chain_q <= load_val;
      cnt     <= '0;
      bpos    <= '0;
      so_q    <= load_val[W-1] ^ mask[W-1];
    end else begin
      if (shift) begin
        chain_q <= {chain_q[W-2:0], si};
        if (cnt != CMAX) cnt <= cnt + 1'b1;
        bpos <= (bpos == PLAST) ? '0 : bpos + 1'b1;
      end
      if (drive) so_q <= so_next;
    end
  end

  // R3: serial output moves only on a falling bit clock or at select fall
  assert_so_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !drive) |=> $stable(so_q));
endmodule

// File: rtl/spi_diag_port.sv
module spi_diag_port #(
  parameter int W  = spi_diag_pkg::WORD_BITS,
  parameter int CH = spi_diag_pkg::CHAN_COUNT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          pwm_mode,
  input  logic [CH-1:0] fault,
  output logic          so,
  output logic          so_oe,
  output logic [CH-1:0] gate_en,
  output logic          mode_mon
);
  localparam int CW = spi_diag_pkg::len_cnt_width(W);
  localparam logic [CW-1:0] LEN_ONE = CW'(W);
  localparam logic [CW-1:0] LEN_TWO = CW'(2 * W);

  logic [1:0]    rise, fall;
  logic          cs_rise, cs_fall, sck_rise, sck_fall;
  logic [CH-1:0] snap;
  logic [W-1:0]  mask, chain, cmd_q;
  logic [CW-1:0] cnt;
  logic          oe_q;

  spi_edge_det #(.N(2), .IDLE(2'b10)) u_edge (
    .clk(clk), .rst(rst), .sig({cs_n, sck}), .rise(rise), .fall(fall)
  );

  assign cs_rise  = rise[1];
  assign cs_fall  = fall[1];
  assign sck_rise = rise[0];
  assign sck_fall = fall[0];

  spi_fault_snap #(.CH(CH)) u_snap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .track(cs_n | cs_fall),
    .fault(fault), .snap(snap)
  );

  always_comb begin
    mask         = '0;
    mask[CH-1:0] = snap;
    mask[CH]     = pwm_mode;
  end

  spi_shift_chain #(.W(W), .CW(CW)) u_chain (
    .clk(clk), .rst(rst), .load(cs_fall),
    .shift(sck_rise & ~cs_n), .drive(sck_fall & ~cs_n), .si(si),
    .load_val(cmd_q), .mask(mask), .chain(chain), .cnt(cnt), .so_q(so)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (cs_rise && (cnt == LEN_ONE || cnt == LEN_TWO)) cmd_q <= chain;
      oe_q <= ~cs_n & ~pwm_mode;
    end
  end

  assign so_oe    = oe_q;
  assign gate_en  = cmd_q[CH-1:0];
  assign mode_mon = cmd_q[CH];

  // R6: enable only after a selected, non-override clock
  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(!cs_n && !pwm_mode));

  // R7: command moves only at the select rising edge
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable(cmd_q));

  // R9: bit clock activity while deselected leaves the length count alone
  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(cnt));
endmodule

// File: tb/sim_spi_diag_port.sv
module sim_spi_diag_port;
  localparam int CLK_PER = 10;

  logic clk = 0, rst = 1, sck = 0, cs_n = 1, si = 0, pwm = 0;
  logic [5:0] fault = '0;
  logic so, so_oe, mode_mon;
  logic [5:0] gate;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] got;

  spi_diag_port u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .pwm_mode(pwm),
    .fault(fault), .so(so), .so_oe(so_oe), .gate_en(gate), .mode_mon(mode_mon)
  );

  always #(CLK_PER / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: stream of bits the host should see.
  logic [7:0] m_cmd = 0;
  logic [5:0] m_snap = 0;
  bit m_oe = 0, m_so = 0, psck = 0, pcs = 1;
  int m_cnt = 0;
  bit stream[$];
  bit inq[$];

  function automatic bit mbit(input int pos, input logic [5:0] s, input bit p);
    if (pos < 6) return s[pos];
    if (pos == 6) return p;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_snap = 0; m_oe = 0; m_so = 0; psck = 0; pcs = 1; m_cnt = 0;
      stream.delete(); inq.delete();
    end else begin
      if (pcs && !cs_n) begin
        m_snap = fault; m_cnt = 0;
        stream.delete(); inq.delete();
        for (int b = 7; b >= 0; b--) stream.push_back(m_cmd[b]);
        m_so = stream[0];
      end else if (!cs_n) begin
        if (sck && !psck) begin
          stream.push_back(si); inq.push_back(si); m_cnt++;
        end
        if (!sck && psck)
          m_so = stream[m_cnt] ^ mbit(7 - (m_cnt % 8), m_snap, pwm);
      end else if (!pcs && cs_n) begin
        if (m_cnt == 8 || m_cnt == 16)
          for (int j = 0; j < 8; j++) m_cmd[7 - j] = inq[inq.size() - 8 + j];
      end
      m_oe = !cs_n && !pwm;
      psck = sck; pcs = cs_n;
    end
  end

  always @(posedge clk) begin
    #(CLK_PER / 4);
    if (!done) begin
      chk(gate == m_cmd[5:0], "R7 model gate", gate, m_cmd[5:0]);
      chk(mode_mon == m_cmd[6], "R2 model mode", mode_mon, m_cmd[6]);
      chk(so_oe == m_oe, "R6 model so_oe", so_oe, m_oe);
      if (m_oe) chk(so == m_so, "R4 model so", so, m_so);
    end
  end

  function automatic logic [7:0] byte_at(input int off);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7 - j] = got[off + j];
    return b;
  endfunction

  task automatic xfer(input int nb, input logic [15:0] data, input logic [5:0] f_fall,
                      input int mid_bit, input logic [5:0] f_mid, input int pwm_bit);
    @(negedge clk); cs_n = 0; fault = f_fall; sck = 0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i == mid_bit) fault = f_mid;
      si = data[nb - 1 - i];
      got[i] = so;
      @(negedge clk); sck = 1;
      @(negedge clk);
      chk(so === got[i], "R3 so still at rise", so, got[i]);
      sck = 0;
      if (i == pwm_bit) pwm = 1;
      @(negedge clk);
      if (i == pwm_bit) pwm = 0;
      @(negedge clk);
    end
    cs_n = 1; si = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(gate == 0 && mode_mon == 0, "R1 reset command", {mode_mon, gate}, 0);
    chk(so_oe == 0, "R1 reset so_oe", so_oe, 0);

    xfer(8, 16'h25, 6'h00, -1, 6'h00, -1);
    chk(gate == 6'h25 && mode_mon == 0, "R2 8-bit command", gate, 6'h25);

    xfer(7, 16'h7F, 6'h00, -1, 6'h00, -1);
    chk(gate == 6'h25, "R7 7-bit ignored", gate, 6'h25);
    xfer(9, 16'h1FF, 6'h00, -1, 6'h00, -1);
    chk(gate == 6'h25, "R7 9-bit ignored", gate, 6'h25);

    xfer(8, 16'h3A, 6'h05, -1, 6'h00, -1);
    chk(byte_at(0) == 8'h20, "R4 fault inversion", byte_at(0), 8'h20);
    chk(gate == 6'h3A, "R2 new command", gate, 6'h3A);

    xfer(8, 16'h11, 6'h00, 2, 6'h3F, -1);
    chk(byte_at(0) == 8'h3A, "R5 mid change frozen", byte_at(0), 8'h3A);

    fault = 6'h00;
    repeat (2) @(negedge clk);
    xfer(8, 16'h55, 6'h0C, -1, 6'h00, -1);
    chk(byte_at(0) == 8'h1D, "R5 fault at select fall", byte_at(0), 8'h1D);

    fault = 6'h00; si = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sck = 1; @(negedge clk); sck = 0;
    end
    si = 0;
    xfer(8, 16'h4F, 6'h00, -1, 6'h00, -1);
    chk(byte_at(0) == 8'h55, "R9 idle clocks ignored", byte_at(0), 8'h55);
    chk(gate == 6'h0F && mode_mon == 1, "R2 mode bit stored", {mode_mon, gate}, 7'h4F);

    xfer(8, 16'h03, 6'h00, -1, 6'h00, 0);
    chk(got[1] == 1'b0, "R4 mode bit inverted", got[1], 0);
    chk(byte_at(0) == 8'h0F, "R4 echo with override", byte_at(0), 8'h0F);

    xfer(16, 16'hA53C, 6'h01, -1, 6'h00, -1);
    chk(byte_at(0) == 8'h02, "R8 first byte out", byte_at(0), 8'h02);
    chk(byte_at(8) == 8'hA4, "R8 second byte echo", byte_at(8), 8'hA4);
    chk(gate == 6'h3C, "R8 second byte command", gate, 6'h3C);

    @(negedge clk); pwm = 1; cs_n = 0;
    repeat (3) @(negedge clk);
    chk(so_oe == 0, "R6 override floats so", so_oe, 0);
    cs_n = 1;
    @(negedge clk); pwm = 0;
    repeat (3) @(negedge clk);
    chk(so_oe == 0, "R6 deselected floats so", so_oe, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule